// File: doc/BRIEF.md
# Offset-Binary Distributed-Arithmetic Inner Product Unit

This block computes the inner product of K signed input words with K fixed signed coefficients without any multiplier. A one-cycle start strobe loads all K words in parallel. The block then walks through the words one bit position per cycle, least significant bit first. For each bit position it reads a partial-sum table and adds the entry into an accumulator or subtracts it. After XW bit cycles the exact result appears on the output, together with a one-cycle valid pulse.

The table stays small because each data bit is recoded from {0,1} to {-1,+1}. With that recoding, inverting every bit of a slice only negates its partial sum. The table therefore holds 2^(K-1) entries, addressed by the other bits XOR'd with the bit of word 0, and the bit of word 0 decides between add and subtract. Recoding shifts every value by a constant. That constant is the negated sum of the coefficients, and the accumulator is preloaded with it once per operation. The sign-bit slice carries negative weight in two's complement, so on that slice the add/subtract choice is inverted.

Top module: `dab_engine`

## Requirements
- R1: After reset, `result_o` is 0 and `valid_o` is 0.
- R2: A start accepted on a clock edge produces `valid_o` high for exactly one cycle, in the cycle that follows the XW-th rising edge after the accepting edge.
- R3: When `valid_o` is high, `result_o` equals the exact sum over k of C_k·x_k. Word k of `data_i` is x_k, taken from bits [k*XW +: XW], and coefficient k is taken from bits [k*CW +: CW] of COEFS. Both are two's complement.
- R4: Results are exact for extreme inputs: all words at the most negative value, all at the most positive value, and all zero.
- R5: A start that arrives while an operation is in progress is ignored. The result and the valid timing of the running operation do not change, and no extra valid pulse follows.
- R6: A start asserted in the same cycle as `valid_o` is accepted. The next result follows XW cycles later.
- R7: `result_o` changes only in a cycle where `valid_o` is high, and it holds its value otherwise.
- R8: The accumulator holds the negated coefficient sum, scaled by 2^XW, in the cycle after an accepted start.
- R9: On the last (sign) slice, the add/subtract choice is the inverse of the bit of word 0. On every other slice it equals that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; loads `data_i` when idle |
| data_i | input | K*XW | K packed two's-complement input words |
| result_o | output | YW | Inner product result, two's complement |
| valid_o | output | 1 | One-cycle pulse when `result_o` is new |

## Verification
Two events can fall in the same cycle: a new start and the valid pulse of the previous operation. The bench provokes this by raising start in exactly the cycle where valid is high. It then judges the completed result and the result of the new operation against a dot product it computes itself, and checks that the second valid arrives XW cycles after the overlap. A second overlap comes from a start pulse sent in the middle of a run. That start must leave the running result and its timing untouched.

// File: rtl/dab_pkg.sv
package dab_pkg;

  // Add (1) or subtract (0) the table entry for a slice. The bit of word 0
  // carries the sign of the recoded slice; the sign slice is inverted.
  function automatic logic slice_add(input logic lsb_word_bit, input logic sign_slice);
    return lsb_word_bit ^ sign_slice;
  endfunction

  // Table address bit: a word's bit relative to the bit of word 0.
  function automatic logic rel_bit(input logic word_bit, input logic ref_bit);
    return word_bit ^ ref_bit;
  endfunction

endpackage

// File: rtl/dab_table.sv
module dab_table #(
  parameter int K  = 4,
  parameter int CW = 8,
  parameter int SW = 11,
  parameter logic [K*CW-1:0] COEFS = '0
) (
  input  logic [K-2:0]          addr,
  output logic signed [SW-1:0]  tval
);
  localparam int NE = 2 ** (K - 1);

  function automatic logic signed [SW-1:0] coef(input int k);
    logic [CW-1:0] raw;
    raw = COEFS[k*CW +: CW];
    return {{(SW-CW){raw[CW-1]}}, raw};
  endfunction

  // Entry e: word 0 recoded as +1; word k as -1 when bit k-1 of e is set.
  function automatic logic signed [SW-1:0] entry_val(input int e);
    logic signed [SW-1:0] s;
    s = coef(0);
    for (int k = 1; k < K; k++) begin
      if (((e >> (k - 1)) & 1) == 1) s = s - coef(k);
      else                            s = s + coef(k);
    end
    return s;
  endfunction

  logic signed [SW-1:0] ent [NE];

  for (genvar e = 0; e < NE; e++) begin : g_ent
    localparam logic signed [SW-1:0] EV = entry_val(e);
    assign ent[e] = EV;
  end

  assign tval = ent[addr];
endmodule

// File: rtl/dab_slice.sv
module dab_slice #(
  parameter int K = 4
) (
  input  logic [K-1:0] bits,
  input  logic         sign_slice,
  output logic [K-2:0] addr,
  output logic         add_op
);
  import dab_pkg::*;

  for (genvar k = 1; k < K; k++) begin : g_addr
    assign addr[k-1] = rel_bit(bits[k], bits[0]);
  end

  assign add_op = slice_add(bits[0], sign_slice);
endmodule

// File: rtl/dab_accum.sv
module dab_accum #(
  parameter int SW = 11,
  parameter int AW = 24,
  parameter int XW = 8,
  parameter logic signed [AW-1:0] PRE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic                 add_op,
  input  logic signed [SW-1:0] tval,
  output logic signed [AW-1:0] acc_q,
  output logic signed [AW-1:0] acc_next
);
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] sum;

  assign term     = {{(AW-SW){tval[SW-1]}}, tval} <<< XW;
  assign sum      = add_op ? (acc_q + term) : (acc_q - term);
  assign acc_next = sum >>> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= PRE;
    else if (step) acc_q <= acc_next;
  end
endmodule

// File: rtl/dab_engine.sv
module dab_engine #(
  parameter int K  = 4,
  parameter int XW = 8,
  parameter int CW = 8,
  parameter logic [K*CW-1:0] COEFS = {8'h37, 8'h0F, 8'hBF, 8'h2D},
  parameter int YW = CW + XW + $clog2(K)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [K*XW-1:0]   data_i,
  output logic [YW-1:0]     result_o,
  output logic              valid_o
);
  localparam int SW  = CW + $clog2(K) + 1;
  localparam int AW  = XW + CW + $clog2(K) + 3;
  localparam int CNW = (XW > 1) ? $clog2(XW) : 1;
  localparam logic [CNW-1:0] LAST = CNW'(XW - 1);

  function automatic logic signed [AW-1:0] coef_sum();
    logic signed [AW-1:0] s;
    logic [CW-1:0] raw;
    s = '0;
    for (int k = 0; k < K; k++) begin
      raw = COEFS[k*CW +: CW];
      s = s + {{(AW-CW){raw[CW-1]}}, raw};
    end
    return s;
  endfunction

  localparam logic signed [AW-1:0] PRE = (-coef_sum()) <<< XW;

  logic                 busy;
  logic                 accept;
  logic                 last_slice;
  logic [CNW-1:0]       slice_cnt;
  logic [K-1:0]         cur_bits;
  logic [K-2:0]         tbl_addr;
  logic                 add_op;
  logic signed [SW-1:0] tval;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_next;
  logic signed [AW-1:0] final_val;

  assign accept     = start_i && !busy;
  assign last_slice = busy && (slice_cnt == LAST);

  for (genvar k = 0; k < K; k++) begin : g_word
    logic [XW-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh <= '0;
      else if (accept) sh <= data_i[k*XW +: XW];
      else if (busy)   sh <= {1'b0, sh[XW-1:1]};
    end
    assign cur_bits[k] = sh[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      slice_cnt <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      slice_cnt <= '0;
    end else if (busy) begin
      busy      <= !last_slice;
      slice_cnt <= slice_cnt + 1'b1;
    end
  end

  dab_slice #(.K(K)) u_slice (
    .bits       (cur_bits),
    .sign_slice (last_slice),
    .addr       (tbl_addr),
    .add_op     (add_op)
  );

  dab_table #(.K(K), .CW(CW), .SW(SW), .COEFS(COEFS)) u_table (
    .addr (tbl_addr),
    .tval (tval)
  );

  dab_accum #(.SW(SW), .AW(AW), .XW(XW), .PRE(PRE)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (busy),
    .add_op   (add_op),
    .tval     (tval),
    .acc_q    (acc_q),
    .acc_next (acc_next)
  );

  // The accumulated value is twice the inner product.
  assign final_val = acc_next >>> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= last_slice;
      if (last_slice) result_o <= final_val[YW-1:0];
    end
  end
endmodule

// File: rtl/dab_chk.sv
module dab_chk #(
  parameter int XW = 8,
  parameter int AW = 24,
  parameter int YW = 18,
  parameter logic signed [AW-1:0] PRE = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic                 busy,
  input logic                 valid_o,
  input logic [YW-1:0]        result_o,
  input logic                 last_slice,
  input logic                 add_op,
  input logic                 b0,
  input logic signed [AW-1:0] acc_q
);
  localparam int TW = $clog2(XW + 2) + 1;
  localparam logic [TW-1:0] TMAX = TW'(XW + 1);

  logic [TW-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            since <= TMAX;
    else if (accept)       since <= '0;
    else if (since != TMAX) since <= since + 1'b1;
  end

  AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (since == TW'(XW))); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R2
  AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !valid_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o)); // R7
  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> (acc_q == PRE)); // R8
  AST_SIGN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (add_op == (b0 ^ last_slice))); // R9
endmodule

bind dab_engine dab_chk #(.XW(XW), .AW(AW), .YW(YW), .PRE(PRE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .busy       (busy),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .last_slice (last_slice),
  .add_op     (add_op),
  .b0         (cur_bits[0]),
  .acc_q      (acc_q)
);

// File: tb/sim_dab_engine.sv
module sim_dab_engine;
  localparam int K  = 4;
  localparam int XW = 8;
  localparam int CW = 8;
  localparam int YW = CW + XW + 2;
  localparam logic [K*CW-1:0] COEFS = {8'h37, 8'h0F, 8'hBF, 8'h2D};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [K*XW-1:0] data_i = '0;
  logic [YW-1:0] result_o;
  logic valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dab_engine #(.K(K), .XW(XW), .CW(CW), .COEFS(COEFS), .YW(YW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  // Bench-side reference: plain multiply-accumulate.
  function automatic longint ref_dot(input logic [K*XW-1:0] d);
    longint s = 0;
    for (int k = 0; k < K; k++)
      s += longint'($signed(COEFS[k*CW +: CW])) * longint'($signed(d[k*XW +: XW]));
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint res_val();
    return longint'($signed(result_o));
  endfunction

  // Start at a negedge and return right after the accepting edge.
  task automatic pulse_start(input logic [K*XW-1:0] d);
    start_i = 1'b1; data_i = d;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Wait the remaining XW edges; check valid timing and result.
  task automatic finish_op(input string req, input logic [K*XW-1:0] d);
    repeat (XW - 1) @(negedge clk);
    check({req, " R2 valid low before"}, valid_o, 0);
    @(negedge clk);
    check({req, " R2 valid"}, valid_o, 1);
    check({req, " R3 result"}, res_val(), ref_dot(d));
  endtask

  task automatic t_reset();
    check("R1 result after reset", res_val(), 0);
    check("R1 valid after reset", valid_o, 0);
  endtask

  task automatic t_extremes();
    logic [K*XW-1:0] d;
    d = {K{8'h80}}; pulse_start(d); finish_op("R4 all min", d);
    @(negedge clk);
    d = {K{8'h7F}}; pulse_start(d); finish_op("R4 all max", d);
    @(negedge clk);
    d = '0;         pulse_start(d); finish_op("R4 all zero", d);
    @(negedge clk);
    d = {8'h7F, 8'h80, 8'hFF, 8'h01}; pulse_start(d); finish_op("R3 mixed", d);
    @(negedge clk);
    check("R2 single pulse", valid_o, 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 150; i++) begin
      logic [K*XW-1:0] d;
      d = {$urandom, $urandom};
      pulse_start(d);
      finish_op("R3 random", d);
      @(negedge clk);
    end
  endtask

  task automatic t_ignore_busy();
    logic [K*XW-1:0] d1, d2;
    d1 = {8'h12, 8'hE4, 8'h5A, 8'h9C};
    d2 = {8'h80, 8'h80, 8'h7F, 8'h7F};
    pulse_start(d1);
    @(negedge clk); @(negedge clk);
    start_i = 1'b1; data_i = d2;
    @(negedge clk);
    start_i = 1'b0;
    repeat (XW - 4) @(negedge clk);
    check("R5 valid low before", valid_o, 0);
    @(negedge clk);
    check("R5 valid timing", valid_o, 1);
    check("R5 result of first op", res_val(), ref_dot(d1));
    repeat (XW + 2) begin
      @(negedge clk);
      check("R5 no extra valid", valid_o, 0);
    end
    check("R7 result held", res_val(), ref_dot(d1));
  endtask

  task automatic t_back_to_back();
    logic [K*XW-1:0] d1, d2;
    d1 = {8'h33, 8'hC8, 8'h01, 8'hFE};
    d2 = {8'h80, 8'h7F, 8'h80, 8'h7F};
    pulse_start(d1);
    repeat (XW - 1) @(negedge clk);
    @(negedge clk);
    check("R6 first valid", valid_o, 1);
    check("R6 first result", res_val(), ref_dot(d1));
    pulse_start(d2);
    check("R6 valid dropped", valid_o, 0);
    check("R7 held after overlap", res_val(), ref_dot(d1));
    finish_op("R6 second", d2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_extremes();
    t_random();
    t_ignore_busy();
    t_back_to_back();
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule